// File: doc/BRIEF.md
# Three-Phase CPU Control Decoder

This block is the combinational control generator of a small 8-bit accumulator-free CPU. Each instruction takes three phases. In phase 0 the opcode byte is fetched. In phase 1 a second byte is fetched, but only for two-byte instructions. In phase 2 the instruction executes. From the current phase, the instruction register and the zero and negative flags of the destination register, the decoder drives every datapath control line. These are the PC load and its source, the loads of the instruction and immediate registers, the memory write strobe, the register-file write enable, and the selects for the address bus, the register write source, the two register ports and the ALU.

The upper nibble of the instruction register is the opcode, and its top bit marks a two-byte form. Bits 3:2 name the destination register and bits 1:0 name the source register. Opcode groups:
- 00xx: ALU operations.
- 0100 / 0101: load and store through Rs.
- 0110: move.
- 0111: no-op.
- 10xx: conditional jumps.
- 1100 / 1101: direct load and store.
- 1110: load immediate.
- 1111: unconditional jump.

Every line whose value does not matter in a given state is driven to 0, so the outputs are fully determined.

Top module: `hw_ctrl_decode`

## Requirements
- R1: With phase 0, `ir_load_o` and `pc_load_o` are 1, `pc_src_o` is 0 (increment), `addr_sel_o` is 0 (PC), and `imm_load_o`, `mem_we_o`, `rd_we_o` and `wr_src_o` are 0, for every opcode and flag value.
- R2: With phase 1 and instruction bit 7 set, `imm_load_o` and `pc_load_o` are 1 and every other strobe and select is 0. With bit 7 clear, all strobes and selects are 0.
- R3: In every phase, `rd_sel_o` equals instruction bits 3:2, `rs_sel_o` equals bits 1:0 and `alu_op_o` equals bits 5:4.
- R4: `mem_we_o` is 1 only in phase 2 with opcode 0101 or 1101 (pattern x101).
- R5: In phase 2, `rd_we_o` is 1 exactly for opcodes 0000-0011, 0100, 0110, 1100 and 1110.
- R6: In phase 2, `wr_src_o` encodes 0 = immediate, 1 = source register, 2 = memory data, 3 = ALU. It is 3 for 00xx, 2 for 0100 and 1100, 1 for 0110, and 0 otherwise.
- R7: In phase 2, `addr_sel_o` encodes 0 = PC, 1 = immediate, 2 = Rs, 3 = Rd. It is 2 for 0100 and 0101, 1 for 1100 and 1101, and 0 otherwise.
- R8: In phase 2, `pc_load_o` is 1 when any of these holds, and 0 for every other opcode whatever the flags:
  - opcode 1111;
  - 1000 with zero set;
  - 1001 with zero clear;
  - 1010 with zero and negative both clear;
  - 1011 with negative set.
- R9: In phase 2, `pc_src_o` is 1 (immediate) for opcodes 10xx and 1111, whether or not the jump is taken. It is 0 otherwise.
- R10: With phase 3, all strobes and the address and write-source selects are 0.
- R11: In phase 2, `ir_load_o` and `imm_load_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_i | input | 2 | Current execution phase (0 fetch, 1 immediate, 2 execute) |
| instr_i | input | 8 | Instruction register contents |
| zero_i | input | 1 | Destination register is zero |
| neg_i | input | 1 | Destination register is negative |
| pc_src_o | output | 1 | PC next source: 0 increment, 1 immediate register |
| pc_load_o | output | 1 | Load PC |
| ir_load_o | output | 1 | Load instruction register |
| imm_load_o | output | 1 | Load immediate register |
| mem_we_o | output | 1 | Memory write (0 read) |
| rd_we_o | output | 1 | Destination register write enable |
| addr_sel_o | output | 2 | Address bus source select |
| wr_src_o | output | 2 | Register write data source select |
| rd_sel_o | output | 2 | Destination register port select |
| rs_sel_o | output | 2 | Source register port select |
| alu_op_o | output | 2 | ALU operation |

## Verification
Phase 2 is the cycle where the flag-driven jump decision and the opcode-driven execute lookup coincide. The flags can therefore leak into a non-jump opcode's PC load, or a store could raise a register write alongside the memory write. The bench drives all 16 opcodes in every phase under all four zero/negative combinations. A scoreboard built from the requirement tables judges each field, so a flag-dependent PC load on a non-jump opcode, or any overlap of store and register write, is reported against its requirement.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
  localparam int unsigned INSTR_W = 8;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_IMM   = 2'd1,
    PH_EXEC  = 2'd2,
    PH_IDLE  = 2'd3
  } phase_e;

  typedef enum logic [SEL_W-1:0] {
    AS_PC  = 2'd0,
    AS_IMM = 2'd1,
    AS_RS  = 2'd2,
    AS_RD  = 2'd3
  } addr_src_e;

  typedef enum logic [SEL_W-1:0] {
    WS_IMM = 2'd0,
    WS_RS  = 2'd1,
    WS_MEM = 2'd2,
    WS_ALU = 2'd3
  } wr_src_e;

  typedef enum logic [OPC_W-1:0] {
    OP_AND  = 4'h0, OP_OR   = 4'h1, OP_ADD  = 4'h2, OP_SUB  = 4'h3,
    OP_LDR  = 4'h4, OP_STR  = 4'h5, OP_MOV  = 4'h6, OP_NOP  = 4'h7,
    OP_JZ   = 4'h8, OP_JNZ  = 4'h9, OP_JPOS = 4'hA, OP_JNEG = 4'hB,
    OP_LDD  = 4'hC, OP_STD  = 4'hD, OP_LDI  = 4'hE, OP_JMP  = 4'hF
  } opc_e;

  typedef struct packed {
    logic      pc_src;
    logic      pc_load;
    logic      ir_load;
    logic      imm_load;
    logic      mem_we;
    logic      rd_we;
    addr_src_e addr_sel;
    wr_src_e   wr_src;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{pc_src: 1'b0, pc_load: 1'b0, ir_load: 1'b0,
                                  imm_load: 1'b0, mem_we: 1'b0, rd_we: 1'b0,
                                  addr_sel: AS_PC, wr_src: WS_IMM};
endpackage

// File: rtl/dec_fields.sv
module dec_fields
  import hwd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output opc_e               opc_o,
  output logic               two_byte_o,
  output logic [SEL_W-1:0]   rd_o,
  output logic [SEL_W-1:0]   rs_o,
  output logic [SEL_W-1:0]   alu_op_o
);
  assign opc_o      = opc_e'(instr_i[INSTR_W-1:OPC_LSB]);
  assign two_byte_o = instr_i[INSTR_W-1];
  assign alu_op_o   = instr_i[OPC_LSB+SEL_W-1:OPC_LSB];
  assign rd_o       = instr_i[2*SEL_W-1:SEL_W];
  assign rs_o       = instr_i[SEL_W-1:0];
endmodule

// File: rtl/dec_exec_lut.sv
module dec_exec_lut
  import hwd_pkg::*;
(
  input  opc_e  opc_i,
  output ctrl_t ctl_o
);
  always_comb begin
    ctl_o = CTRL_IDLE;
    unique case (opc_i)
      OP_AND, OP_OR, OP_ADD, OP_SUB: begin
        ctl_o.rd_we  = 1'b1;
        ctl_o.wr_src = WS_ALU;
      end
      OP_LDR: begin
        ctl_o.rd_we    = 1'b1;
        ctl_o.wr_src   = WS_MEM;
        ctl_o.addr_sel = AS_RS;
      end
      OP_STR: begin
        ctl_o.mem_we   = 1'b1;
        ctl_o.addr_sel = AS_RS;
      end
      OP_MOV: begin
        ctl_o.rd_we  = 1'b1;
        ctl_o.wr_src = WS_RS;
      end
      OP_NOP: ;
      OP_JZ, OP_JNZ, OP_JPOS, OP_JNEG: ctl_o.pc_src = 1'b1; // load gated by branch unit
      OP_LDD: begin
        ctl_o.rd_we    = 1'b1;
        ctl_o.wr_src   = WS_MEM;
        ctl_o.addr_sel = AS_IMM;
      end
      OP_STD: begin
        ctl_o.mem_we   = 1'b1;
        ctl_o.addr_sel = AS_IMM;
      end
      OP_LDI: begin
        ctl_o.rd_we  = 1'b1;
        ctl_o.wr_src = WS_IMM;
      end
      OP_JMP: begin
        ctl_o.pc_src  = 1'b1;
        ctl_o.pc_load = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dec_branch.sv
module dec_branch
  import hwd_pkg::*;
(
  input  opc_e opc_i,
  input  logic zero_i,
  input  logic neg_i,
  output logic take_o
);
  logic       is_cond;
  logic [1:0] cc;
  logic       hit;

  assign is_cond = (opc_i[OPC_W-1 -: 2] == 2'b10);
  assign cc      = opc_i[1:0];

  always_comb begin
    unique case (cc)
      2'd0: hit = zero_i;
      2'd1: hit = !zero_i;
      2'd2: hit = !zero_i && !neg_i;
      2'd3: hit = neg_i;
      default: hit = 1'b0;
    endcase
  end

  assign take_o = is_cond && hit;
endmodule

// File: rtl/hw_ctrl_decode.sv
module hw_ctrl_decode
  import hwd_pkg::*;
(
  input  logic [1:0] phase_i,
  input  logic [7:0] instr_i,
  input  logic       zero_i,
  input  logic       neg_i,
  output logic       pc_src_o,
  output logic       pc_load_o,
  output logic       ir_load_o,
  output logic       imm_load_o,
  output logic       mem_we_o,
  output logic       rd_we_o,
  output logic [1:0] addr_sel_o,
  output logic [1:0] wr_src_o,
  output logic [1:0] rd_sel_o,
  output logic [1:0] rs_sel_o,
  output logic [1:0] alu_op_o
);
  opc_e  opc;
  logic  two_byte;
  ctrl_t exec_ctl;
  ctrl_t ctl;
  logic  take;

  dec_fields u_fields (
    .instr_i   (instr_i),
    .opc_o     (opc),
    .two_byte_o(two_byte),
    .rd_o      (rd_sel_o),
    .rs_o      (rs_sel_o),
    .alu_op_o  (alu_op_o)
  );

  dec_exec_lut u_lut (
    .opc_i(opc),
    .ctl_o(exec_ctl)
  );

  dec_branch u_br (
    .opc_i (opc),
    .zero_i(zero_i),
    .neg_i (neg_i),
    .take_o(take)
  );

  always_comb begin
    ctl = CTRL_IDLE;
    unique case (phase_e'(phase_i))
      PH_FETCH: begin
        ctl.ir_load = 1'b1;
        ctl.pc_load = 1'b1;
      end
      PH_IMM: begin
        ctl.imm_load = two_byte;
        ctl.pc_load  = two_byte;
      end
      PH_EXEC: begin
        ctl         = exec_ctl;
        ctl.pc_load = exec_ctl.pc_load | take;
      end
      default: ;
    endcase
  end

  assign pc_src_o   = ctl.pc_src;
  assign pc_load_o  = ctl.pc_load;
  assign ir_load_o  = ctl.ir_load;
  assign imm_load_o = ctl.imm_load;
  assign mem_we_o   = ctl.mem_we;
  assign rd_we_o    = ctl.rd_we;
  assign addr_sel_o = ctl.addr_sel;
  assign wr_src_o   = ctl.wr_src;
endmodule

// File: rtl/hw_ctrl_decode_sva.sv
module hw_ctrl_decode_sva (
  input logic [1:0] phase_i,
  input logic [7:0] instr_i,
  input logic       zero_i,
  input logic       neg_i,
  input logic       pc_src_o,
  input logic       pc_load_o,
  input logic       ir_load_o,
  input logic       imm_load_o,
  input logic       mem_we_o,
  input logic       rd_we_o,
  input logic [1:0] addr_sel_o,
  input logic [1:0] wr_src_o
);
  always_comb begin
    if (phase_i == 2'd0)
      a_r1_fetch: assert (ir_load_o && pc_load_o && !pc_src_o && addr_sel_o == 2'd0
                          && !mem_we_o && !rd_we_o);
    if (imm_load_o)
      a_r2_imm_two_byte: assert (phase_i == 2'd1 && instr_i[7]);
    if (mem_we_o)
      a_r4_store_only: assert (phase_i == 2'd2 && instr_i[6:4] == 3'b101 && !rd_we_o);
    if (pc_load_o && phase_i == 2'd2)
      a_r9_jump_src: assert (pc_src_o && instr_i[7]);
    if (phase_i == 2'd2 && instr_i[7:6] != 2'b10 && instr_i[7:4] != 4'hF)
      a_r8_no_flag_leak: assert (!pc_load_o);
    if (phase_i == 2'd3)
      a_r10_idle: assert (!pc_load_o && !ir_load_o && !imm_load_o && !mem_we_o && !rd_we_o
                          && addr_sel_o == 2'd0 && wr_src_o == 2'd0);
    if (phase_i == 2'd2)
      a_r11_no_fetch_loads: assert (!ir_load_o && !imm_load_o);
  end

  logic unused_flags;
  assign unused_flags = zero_i ^ neg_i;
endmodule

bind hw_ctrl_decode hw_ctrl_decode_sva u_sva (
  .phase_i   (phase_i),
  .instr_i   (instr_i),
  .zero_i    (zero_i),
  .neg_i     (neg_i),
  .pc_src_o  (pc_src_o),
  .pc_load_o (pc_load_o),
  .ir_load_o (ir_load_o),
  .imm_load_o(imm_load_o),
  .mem_we_o  (mem_we_o),
  .rd_we_o   (rd_we_o),
  .addr_sel_o(addr_sel_o),
  .wr_src_o  (wr_src_o)
);

// File: tb/sim_hw_ctrl_decode.sv
`timescale 1ns/1ps
module sim_hw_ctrl_decode;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] phase;
  logic [7:0] instr;
  logic       zero, neg;
  logic       pc_src, pc_load, ir_load, imm_load, mem_we, rd_we;
  logic [1:0] addr_sel, wr_src, rd_sel, rs_sel, alu_op;

  hw_ctrl_decode u0 (
    .phase_i(phase), .instr_i(instr), .zero_i(zero), .neg_i(neg),
    .pc_src_o(pc_src), .pc_load_o(pc_load), .ir_load_o(ir_load),
    .imm_load_o(imm_load), .mem_we_o(mem_we), .rd_we_o(rd_we),
    .addr_sel_o(addr_sel), .wr_src_o(wr_src), .rd_sel_o(rd_sel),
    .rs_sel_o(rs_sel), .alu_op_o(alu_op)
  );

  // packed: pc_src,pc_load,ir_load,imm_load,mem_we,rd_we,addr[2],wr[2],rd[2],rs[2],alu[2]
  typedef struct packed {
    logic [1:0] ph;
    logic [15:0] v;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit drv_done = 0;

  function automatic logic [15:0] model(input logic [1:0] ph, input logic [7:0] ir,
                                        input logic z, input logic n);
    logic s = 0, pl = 0, il = 0, ml = 0, we = 0, rw = 0;
    logic [1:0] a = 0, w = 0;
    logic [3:0] op = ir[7:4];
    if (ph == 2'd0) begin il = 1; pl = 1; end
    else if (ph == 2'd1) begin ml = ir[7]; pl = ir[7]; end
    else if (ph == 2'd2) begin
      if (op <= 4'd3) begin rw = 1; w = 2'd3; end
      if (op == 4'd4 || op == 4'd12) begin rw = 1; w = 2'd2; end
      if (op == 4'd6) begin rw = 1; w = 2'd1; end
      if (op == 4'd14) rw = 1;
      if (op == 4'd5 || op == 4'd13) we = 1;
      if (op == 4'd4 || op == 4'd5) a = 2'd2;
      if (op == 4'd12 || op == 4'd13) a = 2'd1;
      if (op[3:2] == 2'b10 || op == 4'd15) s = 1;
      pl = (op == 4'd15) || (op == 4'd8 && z) || (op == 4'd9 && !z)
        || (op == 4'd10 && !z && !n) || (op == 4'd11 && n);
    end
    return {s, pl, il, ml, we, rw, a, w, ir[3:2], ir[1:0], ir[5:4]};
  endfunction

  function automatic string tag_of(input logic [1:0] ph, input int f);
    if (f >= 8) return "R3";
    if (ph == 2'd0) return "R1";
    if (ph == 2'd1) return "R2";
    if (ph == 2'd3) return "R10";
    case (f)
      0: return "R9";
      1: return "R8";
      2, 3: return "R11";
      4: return "R4";
      5: return "R5";
      6: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic [1:0] ph, input logic [7:0] ir, input logic z, input logic n);
    item_t it;
    @(posedge clk);
    #1;
    phase = ph; instr = ir; zero = z; neg = n;
    it.ph = ph;
    it.v  = model(ph, ir, z, n);
    q.push_back(it);
  endtask

  // monitor: compare one field at a time
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = {pc_src, pc_load, ir_load, imm_load, mem_we, rd_we,
               addr_sel, wr_src, rd_sel, rs_sel, alu_op};
        for (int f = 0; f < 11; f++) begin
          int lo, w, av, ev;
          lo = (f < 6) ? 15 - f : 14 - 2 * (f - 6) - 1 + 1 - 1;
          if (f < 6) begin w = 1; lo = 15 - f; end
          else begin w = 2; lo = 8 - 2 * (f - 6); end
          av = (w == 1) ? int'(act[lo]) : int'(act[lo +: 2]);
          ev = (w == 1) ? int'(it.v[lo]) : int'(it.v[lo +: 2]);
          checks++;
          if (av != ev) begin
            errors++;
            $display("FAIL %s field %0d phase %0d: actual %0d expected %0d",
                     tag_of(it.ph, f), f, it.ph, av, ev);
          end
        end
      end
    end
  end

  initial begin
    phase = 0; instr = 0; zero = 0; neg = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state / fetch check (R1)
    drive(2'd0, 8'h00, 1'b0, 1'b0);
    // full sweep: R1..R11
    for (int ph = 0; ph < 4; ph++)
      for (int op = 0; op < 16; op++)
        for (int zn = 0; zn < 4; zn++)
          drive(2'(ph), {4'(op), 2'(op + zn), 2'(op * 3 + ph)}, zn[1], zn[0]);
    // jump corner: zero and negative both set on JPOS (R8) and JNEG
    drive(2'd2, 8'hA5, 1'b1, 1'b1);
    drive(2'd2, 8'hB5, 1'b1, 1'b1);
    drive(2'd2, 8'hD4, 1'b1, 1'b0); // R4 direct store
    @(posedge clk);
    @(posedge clk);
    drv_done = 1;
  end

  initial begin
    int cyc = 0;
    while (!(drv_done && q.size() == 0) && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule